// File: doc/BRIEF.md
# Exception Priority Sequencer

This block sits between an instruction-completion point and an exception-processing unit. When an instruction completes, it takes a snapshot of every exception event that applies to that instruction: a forced exception, a trace exception, a pending breakpoint and a pending interrupt. It then hands these events to the downstream unit one at a time, in a fixed order, over a valid/ready stream. The downstream unit owns vector fetch, stacking and the handlers. This block only decides which events are taken and in what order.

A trace event is produced only for an instruction that actually executed and only while tracing is enabled. An instruction that is rejected (illegal, unimplemented or privileged) produces no trace event. If a stop-type instruction completes while tracing is enabled, the block raises a plain level output that tells the core not to enter the stopped state. The core then carries on with the next instruction once the trace handler returns.

Back-pressure rules on the event stream: an event is transferred on a clock edge where `evt_valid_o` and `evt_ready_i` are both high. While `evt_valid_o` is high and `evt_ready_i` is low, `evt_kind_o` holds its value. The next event appears in the cycle after a transfer. New completions are not accepted while any snapshot event is still undelivered, so the stream never drops or reorders an event.

Top module: `exc_seq`

## Requirements
- R1: A synchronous active-high `rst` clears every latched event. In the cycle after reset, `evt_valid_o`=0, `evt_kind_o`=0 and `stop_suppress_o`=0.
- R2: When `done_i` is high on a clock edge while no event is latched, the event set is captured. `evt_valid_o` rises in the cycle after that edge whenever at least one event was captured.
- R3: A forced exception (`forced_i`=1 at capture) is delivered first, with kind code 1.
- R4: A trace event (kind code 2) is captured when `trace_en_i`=1 and `executed_i`=1. It is delivered after any forced exception and before any breakpoint or interrupt.
- R5: An instruction with `executed_i`=0 produces no trace event even with `trace_en_i`=1. Its other events are still delivered.
- R6: A breakpoint (`bkpt_pend_i`, kind code 3) is delivered before an interrupt (`irq_pend_i`, kind code 4).
- R7: Exactly one event is removed per edge with `evt_valid_o`=1 and `evt_ready_i`=1. While `evt_ready_i`=0, `evt_valid_o` stays 1 and `evt_kind_o` is stable. When `evt_valid_o`=0, `evt_kind_o`=0.
- R8: `done_i` is ignored while any latched event is undelivered. The delivered sequence and `stop_suppress_o` are unaffected.
- R9: On each accepted completion, `stop_suppress_o` is loaded with `stop_i & trace_en_i & executed_i`. It holds that value until the next accepted completion or reset.
- R10: An accepted completion with no event leaves `evt_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Instruction-complete strobe |
| executed_i | input | 1 | 1 = instruction executed, 0 = rejected |
| forced_i | input | 1 | Instruction forced an exception |
| trace_en_i | input | 1 | Trace mode enabled |
| irq_pend_i | input | 1 | Interrupt pending at completion |
| bkpt_pend_i | input | 1 | Breakpoint pending at completion |
| stop_i | input | 1 | Completing instruction is a stop or low-power stop |
| evt_valid_o | output | 1 | Event stream valid |
| evt_ready_i | input | 1 | Event stream ready (downstream accepts) |
| evt_kind_o | output | 3 | Event kind: 0 none, 1 forced, 2 trace, 3 breakpoint, 4 interrupt |
| stop_suppress_o | output | 1 | Cancel the stopped state for the current stop instruction |

## Verification
The bench builds the block with its default four event slots and a three-bit kind code. These are the only values the ordering is defined for. With that configuration, all 64 combinations of the six completion inputs can be swept. Each combination is paired with zero to two stall cycles per event. During those stalls the bench fires completions carrying the opposite inputs. This brings every ordering, every trace-rejection case, the stop-suppress cases and the busy-strobe rule within reach. A mid-sequence reset covers the clearing path.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned EVT_N  = 4;
  localparam int unsigned KIND_W = $clog2(EVT_N + 1);

  // slot index is the delivery rank; kind code = slot + 1
  localparam int unsigned SLOT_FORCED = 0;
  localparam int unsigned SLOT_TRACE  = 1;
  localparam int unsigned SLOT_BKPT   = 2;
  localparam int unsigned SLOT_IRQ    = 3;

  typedef enum logic [KIND_W-1:0] {
    EK_NONE   = 3'd0,
    EK_FORCED = 3'd1,
    EK_TRACE  = 3'd2,
    EK_BKPT   = 3'd3,
    EK_IRQ    = 3'd4
  } exc_kind_e;
endpackage

// File: rtl/exc_capture.sv
module exc_capture
  import exc_seq_pkg::*;
#(
  parameter int unsigned N = EVT_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done_i,
  input  logic         executed_i,
  input  logic         forced_i,
  input  logic         trace_en_i,
  input  logic         irq_pend_i,
  input  logic         bkpt_pend_i,
  input  logic         stop_i,
  input  logic [N-1:0] clear_i,
  output logic [N-1:0] pend_o,
  output logic         suppress_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] snap;
  logic         sup_q;
  logic         accept;
  logic         traced;

  assign traced = trace_en_i & executed_i;
  assign accept = done_i & ~(|pend_q);

  always_comb begin
    snap              = '0;
    snap[SLOT_FORCED] = forced_i;
    snap[SLOT_TRACE]  = traced;
    snap[SLOT_BKPT]   = bkpt_pend_i;
    snap[SLOT_IRQ]    = irq_pend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      sup_q  <= 1'b0;
    end else if (accept) begin
      pend_q <= snap;
      sup_q  <= stop_i & traced;
    end else begin
      pend_q <= pend_q & ~clear_i;
    end
  end

  assign pend_o     = pend_q;
  assign suppress_o = sup_q;

  AST_REJECT_NO_TRACE: assert property (@(posedge clk) disable iff (rst)
    (accept && !executed_i) |=> !pend_q[SLOT_TRACE]);                 // R5
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((|pend_q) && clear_i == '0) |=> $stable(pend_q) && $stable(sup_q)); // R8
  AST_SUPPRESS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (accept && stop_i && trace_en_i && executed_i) |=> sup_q);         // R9
  AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(sup_q));                                       // R9
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign grant_o[i] = req_i[i] & ~seen[i];
    if (i < N - 1) begin : g_chain
      assign seen[i+1] = seen[i] | req_i[i];
    end
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o));                        // R7
    AST_GRANT_IF_REQ: assert ((req_i == '0) || (grant_o != '0));       // R7
  end
endmodule

// File: rtl/exc_encode.sv
module exc_encode #(
  parameter int unsigned N      = 4,
  parameter int unsigned KIND_W = 3
) (
  input  logic [N-1:0]      grant_i,
  output logic [KIND_W-1:0] kind_o
);
  always_comb begin
    kind_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_i[i]) kind_o = KIND_W'(i + 1);
    end
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              executed_i,
  input  logic              forced_i,
  input  logic              trace_en_i,
  input  logic              irq_pend_i,
  input  logic              bkpt_pend_i,
  input  logic              stop_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [KIND_W-1:0] evt_kind_o,
  output logic              stop_suppress_o
);
  logic [EVT_N-1:0] pend;
  logic [EVT_N-1:0] grant;
  logic [EVT_N-1:0] clear;
  logic             take;

  exc_capture #(.N(EVT_N)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .done_i      (done_i),
    .executed_i  (executed_i),
    .forced_i    (forced_i),
    .trace_en_i  (trace_en_i),
    .irq_pend_i  (irq_pend_i),
    .bkpt_pend_i (bkpt_pend_i),
    .stop_i      (stop_i),
    .clear_i     (clear),
    .pend_o      (pend),
    .suppress_o  (stop_suppress_o)
  );

  exc_pick #(.N(EVT_N)) u_pick (
    .req_i   (pend),
    .grant_o (grant)
  );

  exc_encode #(.N(EVT_N), .KIND_W(KIND_W)) u_encode (
    .grant_i (grant),
    .kind_o  (evt_kind_o)
  );

  assign evt_valid_o = |pend;
  assign take        = evt_valid_o & evt_ready_i;
  assign clear       = take ? grant : '0;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o && !evt_ready_i) |=> evt_valid_o && $stable(evt_kind_o)); // R7
  AST_IDLE_KIND: assert property (@(posedge clk) disable iff (rst)
    !evt_valid_o |-> evt_kind_o == EK_NONE);                            // R7
  AST_FORCED_FIRST: assert property (@(posedge clk) disable iff (rst)
    pend[SLOT_FORCED] |-> evt_kind_o == EK_FORCED);                     // R3
  AST_TRACE_BEFORE: assert property (@(posedge clk) disable iff (rst)
    (pend[SLOT_TRACE] && !pend[SLOT_FORCED]) |-> evt_kind_o == EK_TRACE); // R4
  AST_BKPT_BEFORE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (evt_kind_o == EK_IRQ) |-> !pend[SLOT_BKPT]);                       // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !evt_valid_o && !stop_suppress_o);                          // R1
endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       done_i = 1'b0;
  logic       executed_i = 1'b0;
  logic       forced_i = 1'b0;
  logic       trace_en_i = 1'b0;
  logic       irq_pend_i = 1'b0;
  logic       bkpt_pend_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       evt_valid_o;
  logic       evt_ready_i = 1'b0;
  logic [2:0] evt_kind_o;
  logic       stop_suppress_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq uut (
    .clk             (clk),
    .rst             (rst),
    .done_i          (done_i),
    .executed_i      (executed_i),
    .forced_i        (forced_i),
    .trace_en_i      (trace_en_i),
    .irq_pend_i      (irq_pend_i),
    .bkpt_pend_i     (bkpt_pend_i),
    .stop_i          (stop_i),
    .evt_valid_o     (evt_valid_o),
    .evt_ready_i     (evt_ready_i),
    .evt_kind_o      (evt_kind_o),
    .stop_suppress_o (stop_suppress_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    executed_i  = v[0];
    forced_i    = v[1];
    trace_en_i  = v[2];
    irq_pend_i  = v[3];
    bkpt_pend_i = v[4];
    stop_i      = v[5];
  endtask

  function automatic string tag_of(input int kind, input bit rejected_trace);
    case (kind)
      1: return "R3 forced";
      2: return "R4 trace";
      3: return "R6 breakpoint";
      4: return "R6 interrupt";
      default: return rejected_trace ? "R5 none" : "R7 none";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after reset", int'(evt_valid_o), 0);
    chk("R1 kind after reset", int'(evt_kind_o), 0);
    chk("R1 suppress after reset", int'(stop_suppress_o), 0);

    for (int v = 0; v < 64; v++) begin
      int exp_k[4];
      int n;
      int stall;
      bit ex, fo, te, ir, bk, st;
      ex = v[0]; fo = v[1]; te = v[2]; ir = v[3]; bk = v[4]; st = v[5];
      n = 0;
      if (fo) begin exp_k[n] = 1; n++; end
      if (te && ex) begin exp_k[n] = 2; n++; end
      if (bk) begin exp_k[n] = 3; n++; end
      if (ir) begin exp_k[n] = 4; n++; end
      stall = v % 3;

      chk("R2 idle before strobe", int'(evt_valid_o), 0);
      drive(6'(v));
      done_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0;
      drive(6'(~v));
      chk("R9 suppress load", int'(stop_suppress_o), int'(st && te && ex));
      chk(n == 0 ? "R10 no event" : "R2 valid after capture",
          int'(evt_valid_o), int'(n != 0));

      for (int k = 0; k < n; k++) begin
        for (int s = 0; s < stall; s++) begin
          chk("R7 hold valid in stall", int'(evt_valid_o), 1);
          chk("R7 hold kind in stall", int'(evt_kind_o), exp_k[k]);
          done_i = 1'b1;   // R8: must be ignored while busy
          @(negedge clk);
          done_i = 1'b0;
          chk("R8 suppress unaffected by busy strobe",
              int'(stop_suppress_o), int'(st && te && ex));
        end
        chk("R7 valid", int'(evt_valid_o), 1);
        chk(tag_of(exp_k[k], 1'b0), int'(evt_kind_o), exp_k[k]);
        evt_ready_i = 1'b1;
        @(negedge clk);
        evt_ready_i = 1'b0;
      end
      chk(tag_of(0, te && !ex), int'(evt_valid_o), 0);
      chk("R7 kind zero when idle", int'(evt_kind_o), 0);
      chk("R9 suppress held", int'(stop_suppress_o), int'(st && te && ex));
    end

    // mid-sequence reset: R1
    drive(6'b111111);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    chk("R9 suppress before reset", int'(stop_suppress_o), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid cleared", int'(evt_valid_o), 0);
    chk("R1 kind cleared", int'(evt_kind_o), 0);
    chk("R1 suppress cleared", int'(stop_suppress_o), 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule